// File: doc/BRIEF.md
# Instruction Byte Fetcher with External Mode Decode

This block fetches one variable-length instruction from a byte-wide synchronous read port. When it accepts a start request it reads the opcode byte at the given 16-bit address. It then shows that opcode to an external decoder and takes back a 4-bit addressing-mode code. The number of operand bytes still to read depends on that code: none, one or two.

When the last byte has arrived, the block raises a one-cycle done strobe. At that point it presents the opcode, the first and second operand bytes and the instruction length in bytes. The opcode-to-mode table is kept outside the block so that one fetcher can serve any opcode map. Executing the fetched instruction is left to downstream logic.

Each memory read takes two cycles. In the first cycle the block drives the address and the read strobe. The data is taken from the port at the clock edge that ends the following cycle. Reads never overlap.

Top module: `instr_fetcher`

## Requirements
- R1: After reset, `busy`, `doneStb`, `memRdEn` and `decodeReq` are 0, and `instrOpcode`, `instrOp1`, `instrOp2` and `instrLen` are all 0.
- R2: A high `startValid` sampled at a clock edge while `busy` is low starts a fetch. In the next cycle `busy` is high, `memRdEn` is high and `memAddr` equals the captured `startAddr`.
- R3: `memRdEn` is high for exactly one cycle per read and is never high in two consecutive cycles. The read data is taken from `memRdData` at the clock edge that ends the cycle after the strobe.
- R4: After the opcode arrives, `decodeReq` is high for exactly one cycle and `decodeOpcode` equals the fetched opcode during that cycle. `modeIn` is sampled only in that cycle.
- R5: Mode codes 2 through 9 each cause exactly one operand byte to be read. These codes are immediate, zero-page, zero-page+X, zero-page+Y, zero-page indirect, zero-page indexed-indirect, zero-page indirect-indexed and relative.
- R6: Mode codes 10 through 14 each cause two operand bytes to be read. These codes are absolute, absolute+X, absolute+Y, absolute indirect and absolute indexed-indirect.
- R7: Mode codes 0 (implied), 1 (accumulator) and 15 (any other mode) cause no operand read.
- R8: The first operand byte is read from start+1 and is presented on `instrOp1`, which is the low byte of a 16-bit operand. The second operand byte is read from start+2 and is presented on `instrOp2`, which is the high byte.
- R9: `instrLen` equals 1 plus the operand count. `doneStb` is a single-cycle pulse that goes high 3, 5 or 7 cycles after the start edge for lengths 1, 2 and 3. `busy` falls in the cycle after the pulse.
- R10: An operand byte that was not fetched is presented as 0 while `doneStb` is high.
- R11: `startValid` has no effect while `busy` is high. No extra read and no extra done pulse results from it.
- R12: Operand addresses wrap modulo 65536, so a start at 0xFFFF reads its operands from 0x0000 and 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request to fetch at `startAddr` |
| startAddr | input | 16 | Address of the opcode byte |
| busy | output | 1 | A fetch is in progress |
| memRdEn | output | 1 | Read strobe for the memory port |
| memAddr | output | 16 | Read address |
| memRdData | input | 8 | Read data, valid the cycle after the strobe |
| decodeReq | output | 1 | Opcode is presented for mode decode |
| decodeOpcode | output | 8 | Opcode shown to the external decoder |
| modeIn | input | 4 | Addressing-mode code from the decoder |
| doneStb | output | 1 | One-cycle strobe: instruction complete |
| instrOpcode | output | 8 | Fetched opcode |
| instrOp1 | output | 8 | First operand byte (low byte) |
| instrOp2 | output | 8 | Second operand byte (high byte) |
| instrLen | output | 2 | Instruction length in bytes (1 to 3) |

## Verification
A wrong operand counter or wrong state shows up within one read at the memory port. The next strobe then carries an address that does not match the expected start+1 or start+2 sequence, or arrives one cycle too early. If the mode classification is wrong, the done pulse moves by two cycles and `instrLen` is wrong. If the operand registers are not cleared, stale bytes appear in the done cycle of the next short instruction. The memory model's data depends on the address, so a byte stored in the wrong slot is seen at the done strobe.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int OPS_MAX = 2;
  localparam int IDX_W   = $clog2(OPS_MAX + 1);
  localparam int LEN_W   = $clog2(OPS_MAX + 2);

  typedef enum logic [3:0] {
    MODE_IMPL    = 4'd0,
    MODE_ACC     = 4'd1,
    MODE_IMM     = 4'd2,
    MODE_ZP      = 4'd3,
    MODE_ZPX     = 4'd4,
    MODE_ZPY     = 4'd5,
    MODE_ZPIND   = 4'd6,
    MODE_ZPXIND  = 4'd7,
    MODE_ZPINDY  = 4'd8,
    MODE_REL     = 4'd9,
    MODE_ABS     = 4'd10,
    MODE_ABSX    = 4'd11,
    MODE_ABSY    = 4'd12,
    MODE_ABSIND  = 4'd13,
    MODE_ABSXIND = 4'd14,
    MODE_OTHER   = 4'd15
  } addrMode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_CAPTURE, ST_DECODE, ST_FINISH
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadBase;
    logic             capEn;
    logic [IDX_W-1:0] idx;
    logic             loadLen;
  } fetchStrobes_t;
endpackage

// File: rtl/fetch_mode_sizer.sv
module fetch_mode_sizer
  import fetch_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic [MODE_W-1:0] modeCode,
  output logic [IDX_W-1:0]  opCount
);
  addrMode_t modeEnum;
  assign modeEnum = addrMode_t'(modeCode[3:0]);

  always_comb begin
    unique case (modeEnum)
      MODE_IMM, MODE_ZP, MODE_ZPX, MODE_ZPY,
      MODE_ZPIND, MODE_ZPXIND, MODE_ZPINDY, MODE_REL:
        opCount = IDX_W'(1);
      MODE_ABS, MODE_ABSX, MODE_ABSY, MODE_ABSIND, MODE_ABSXIND:
        opCount = IDX_W'(2);
      default:
        opCount = '0;
    endcase
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [IDX_W-1:0] opCount,
  output fetchStrobes_t    strobes,
  output logic             busy,
  output logic             memRdEn,
  output logic             decodeReq,
  output logic             doneStb
);
  fetchState_t stateQ, stateD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic [IDX_W-1:0] needQ, needD;

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    needD  = needQ;
    strobes = '0;
    strobes.idx = idxQ;
    unique case (stateQ)
      ST_IDLE: if (startValid) begin
        strobes.loadBase = 1'b1;
        idxD   = '0;
        stateD = ST_ISSUE;
      end
      ST_ISSUE: stateD = ST_CAPTURE;
      ST_CAPTURE: begin
        strobes.capEn = 1'b1;
        if (idxQ == '0)         stateD = ST_DECODE;
        else if (idxQ == needQ) stateD = ST_FINISH;
        else begin
          idxD   = idxQ + IDX_W'(1);
          stateD = ST_ISSUE;
        end
      end
      ST_DECODE: begin
        strobes.loadLen = 1'b1;
        needD = opCount;
        if (opCount == '0) stateD = ST_FINISH;
        else begin
          idxD   = IDX_W'(1);
          stateD = ST_ISSUE;
        end
      end
      ST_FINISH: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      needQ  <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
      needQ  <= needD;
    end
  end

  assign busy      = (stateQ != ST_IDLE);
  assign memRdEn   = (stateQ == ST_ISSUE);
  assign decodeReq = (stateQ == ST_DECODE);
  assign doneStb   = (stateQ == ST_FINISH);
endmodule

// File: rtl/fetch_dpath.sv
module fetch_dpath
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobes_t     strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [IDX_W-1:0]  opCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] byte0,
  output logic [DATA_W-1:0] byte1,
  output logic [DATA_W-1:0] byte2,
  output logic [LEN_W-1:0]  instrLen
);
  localparam int NBYTES = OPS_MAX + 1;

  logic [ADDR_W-1:0] baseQ;
  logic [NBYTES-1:0][DATA_W-1:0] bytesQ;

  always_ff @(posedge clk) begin
    if (!rstN)                 baseQ <= '0;
    else if (strobes.loadBase) baseQ <= startAddr;
  end

  // modulo 2^ADDR_W by truncation
  assign memAddr = baseQ + ADDR_W'(strobes.idx);

  for (genvar g = 0; g < NBYTES; g++) begin : gen_slot
    always_ff @(posedge clk) begin
      if (!rstN || strobes.loadBase)
        bytesQ[g] <= '0;
      else if (strobes.capEn && strobes.idx == IDX_W'(g))
        bytesQ[g] <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.loadBase) instrLen <= '0;
    else if (strobes.loadLen)      instrLen <= LEN_W'(opCount) + LEN_W'(1);
  end

  assign byte0 = bytesQ[0];
  assign byte1 = bytesQ[1];
  assign byte2 = bytesQ[2];
endmodule

// File: rtl/instr_fetcher.sv
module instr_fetcher
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              decodeReq,
  output logic [DATA_W-1:0] decodeOpcode,
  input  logic [MODE_W-1:0] modeIn,
  output logic              doneStb,
  output logic [DATA_W-1:0] instrOpcode,
  output logic [DATA_W-1:0] instrOp1,
  output logic [DATA_W-1:0] instrOp2,
  output logic [LEN_W-1:0]  instrLen
);
  fetchStrobes_t strobes;
  logic [IDX_W-1:0] opCount;

  fetch_mode_sizer #(.MODE_W(MODE_W)) u_sizer (
    .modeCode(modeIn), .opCount(opCount)
  );

  fetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opCount(opCount),
    .strobes(strobes), .busy(busy), .memRdEn(memRdEn),
    .decodeReq(decodeReq), .doneStb(doneStb)
  );

  fetch_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startAddr(startAddr),
    .memRdData(memRdData), .opCount(opCount), .memAddr(memAddr),
    .byte0(instrOpcode), .byte1(instrOp1), .byte2(instrOp2),
    .instrLen(instrLen)
  );

  assign decodeOpcode = instrOpcode;
endmodule

// File: rtl/instr_fetcher_chk.sv
module instr_fetcher_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [ADDR_W-1:0] startAddr,
  input logic              busy,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              decodeReq,
  input logic              doneStb,
  input logic [DATA_W-1:0] instrOp1,
  input logic [DATA_W-1:0] instrOp2,
  input logic [1:0]        instrLen
);
  // R2
  start_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid) |=> (busy && memRdEn && memAddr == $past(startAddr)));
  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);
  // R4
  decode_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    decodeReq |=> !decodeReq);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> (!doneStb && !busy));
  // R9
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (instrLen != 2'd0));
  // R10
  unfetched_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && instrLen == 2'd1) |-> (instrOp1 == '0 && instrOp2 == '0));
  // R10
  unfetched_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && instrLen == 2'd2) |-> (instrOp2 == '0));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneStb) |=> busy);
endmodule

bind instr_fetcher instr_fetcher_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
  .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr), .decodeReq(decodeReq),
  .doneStb(doneStb), .instrOp1(instrOp1), .instrOp2(instrOp2),
  .instrLen(instrLen)
);

// File: tb/instr_fetcher_bench.sv
`timescale 1ns/1ps
module instr_fetcher_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [15:0] startAddr = '0;
  logic busy, memRdEn, decodeReq, doneStb;
  logic [15:0] memAddr;
  logic [7:0] memRdData = '0;
  logic [7:0] decodeOpcode, instrOpcode, instrOp1, instrOp2;
  logic [3:0] modeIn;
  logic [3:0] curMode = '0;
  logic [1:0] instrLen;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic prevRd = 1'b0;

  typedef struct packed {
    logic [7:0] opc;
    logic [7:0] op1;
    logic [7:0] op2;
    logic [1:0] len;
    logic [7:0] lat;
    logic [31:0] startCyc;
  } expItem_t;

  expItem_t expQ[$];
  logic [15:0] addrQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  instr_fetcher u_instr_fetcher (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .decodeReq(decodeReq), .decodeOpcode(decodeOpcode), .modeIn(modeIn),
    .doneStb(doneStb), .instrOpcode(instrOpcode), .instrOp1(instrOp1),
    .instrOp2(instrOp2), .instrLen(instrLen)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'h3B) ^ 8'h5A;
  endfunction

  // Operand count per mode code (R5, R6, R7)
  function automatic int opsFor(input logic [3:0] m);
    if (m >= 4'd2 && m <= 4'd9)  return 1;
    if (m >= 4'd10 && m <= 4'd14) return 2;
    return 0;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memFn(memAddr);
  // junk outside the decode cycle exposes sampling at the wrong time (R4)
  assign modeIn = decodeReq ? curMode : 4'hB;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares design activity against queued expectations
  always @(negedge clk) begin
    if (rstN) begin
      if (memRdEn) begin
        check(!prevRd, "R3", "back-to-back read strobe", 1, 0);
        if (addrQ.size() == 0) check(1'b0, "R11", "unexpected read", memAddr, 0);
        else begin
          logic [15:0] ea;
          ea = addrQ.pop_front();
          check(memAddr == ea, "R8/R12", "read address", memAddr, ea);
        end
      end
      prevRd = memRdEn;
      if (decodeReq && expQ.size() != 0)
        check(decodeOpcode == expQ[0].opc, "R4", "decode opcode", decodeOpcode, expQ[0].opc);
      if (doneStb) begin
        if (expQ.size() == 0) check(1'b0, "R11", "unexpected done", 1, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          check(instrOpcode == e.opc, "R2", "opcode", instrOpcode, e.opc);
          check(instrOp1 == e.op1, "R8", "operand 1", instrOp1, e.op1);
          check(instrOp2 == e.op2, "R10", "operand 2", instrOp2, e.op2);
          check(instrLen == e.len, "R9", "length", instrLen, e.len);
          check(cyc - int'(e.startCyc) == int'(e.lat), "R9", "latency",
                cyc - int'(e.startCyc), e.lat);
        end
      end
    end
  end

  // Driver: issues one fetch and queues what it must produce
  task automatic runInstr(input logic [15:0] a, input logic [3:0] m, input bit poke);
    int n;
    expItem_t e;
    n = opsFor(m);
    e.opc = memFn(a);
    e.op1 = (n >= 1) ? memFn(a + 16'd1) : 8'h00;
    e.op2 = (n >= 2) ? memFn(a + 16'd2) : 8'h00;
    e.len = 2'(n + 1);
    e.lat = 8'(2 * (n + 1) + 1);
    addrQ.push_back(a);
    for (int k = 1; k <= n; k++) addrQ.push_back(a + 16'(k));
    @(negedge clk);
    curMode = m;
    startAddr = a;
    startValid = 1'b1;
    @(negedge clk);
    e.startCyc = 32'(cyc);
    expQ.push_back(e);
    startValid = 1'b0;
    if (poke) begin
      // R11: restart attempt mid-fetch must be ignored
      startAddr = 16'h1234;
      startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && addrQ.size() == 0, "R11", "queue drained",
          expQ.size() + addrQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !doneStb && !memRdEn && !decodeReq, "R1", "control outputs",
          {busy, doneStb, memRdEn, decodeReq}, 0);
    check(instrOpcode == 0 && instrOp1 == 0 && instrOp2 == 0 && instrLen == 0,
          "R1", "data outputs", {instrOpcode, instrOp1, instrOp2}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "idle after reset", busy, 0);
    // R7 zero-operand codes
    runInstr(16'h0200, 4'd0, 1'b0);
    runInstr(16'h0301, 4'd1, 1'b0);
    runInstr(16'h4410, 4'd15, 1'b0);
    // R5 one-operand codes
    for (int m = 2; m <= 9; m++) runInstr(16'h1000 + 16'(m * 37), 4'(m), 1'b0);
    // R6 two-operand codes
    for (int m = 10; m <= 14; m++) runInstr(16'h8000 + 16'(m * 91), 4'(m), 1'b0);
    // R10 short instruction right after a long one: no stale operand
    runInstr(16'h8123, 4'd10, 1'b0);
    runInstr(16'h2222, 4'd0, 1'b0);
    runInstr(16'h8123, 4'd11, 1'b0);
    runInstr(16'h3333, 4'd3, 1'b0);
    // R12 wrap at top of address space
    runInstr(16'hFFFF, 4'd10, 1'b0);
    runInstr(16'hFFFE, 4'd12, 1'b0);
    runInstr(16'hFFFF, 4'd2, 1'b0);
    // R11 start ignored while busy
    runInstr(16'h5000, 4'd13, 1'b1);
    runInstr(16'h6000, 4'd0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    check(1'b0, "R9", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule